// File: doc/BRIEF.md
# Ternary Lookup Table with Lowest-Index Priority

This block is a small ternary content-addressable table. Every entry holds a value word, a per-bit care mask and a valid flag. A bit whose care flag is clear is a wildcard and accepts either key value. A search key is compared against all entries at once. The registered answer reports whether any valid entry accepted the key, and which one won.

When several entries accept the key, the one with the smallest index wins. Software that stores longer prefixes at smaller indices therefore gets longest-prefix routing. Entries are loaded or removed one at a time through a write port, and the rest of the table is left untouched. A write and a search may arrive in the same cycle. The search then sees the table as it was before that write.

Top module: `tcam_lookup`

## Requirements
- R1: After reset every entry is invalid and `res_valid`, `res_hit` and `res_idx` are 0. A search before any write misses, even though the cleared contents would otherwise accept any key.
- R2: An entry with every care bit set (`1` = compare) accepts only a key equal to its value. A key that differs in a single cared bit is rejected.
- R3: A bit whose care bit is 0 is a wildcard and accepts either key value in that position.
- R4: When several entries accept the key, `res_idx` reports the lowest such index. Storing longer prefixes at lower indices yields longest-prefix matching.
- R5: When no entry accepts the key, `res_hit` is 0 and `res_idx` is 0.
- R6: A write with `wr_en`=1 loads value, care mask and valid flag into entry `wr_idx` and leaves every other entry unchanged.
- R7: An entry written with `wr_valid`=0 never accepts any key.
- R8: `res_valid` is 1 in exactly the cycle after each cycle with `srch_en`=1. The `res_hit` and `res_idx` values in that cycle belong to that search.
- R9: When a write and a search occur in the same cycle, the search result reflects the table contents from before that write.
- R10: The highest index is searchable, and an all-wildcard valid entry accepts every key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_idx | input | IDX_W | Entry index to load |
| wr_value | input | KEY_W | Value word to store |
| wr_care | input | KEY_W | Per-bit care mask, 1 = compare, 0 = wildcard |
| wr_valid | input | 1 | Valid flag to store with the entry |
| srch_en | input | 1 | Search strobe |
| srch_key | input | KEY_W | Key to look up |
| res_valid | output | 1 | Result strobe, one cycle after `srch_en` |
| res_hit | output | 1 | Some valid entry accepted the key |
| res_idx | output | IDX_W | Lowest accepting index, 0 on a miss |

## Verification
The hardest situation to reach from the ports is a write and a search landing on the same entry in one cycle. Only there can a design that forwards the incoming write be told apart from one that searches the old table. The stimulus first leaves the target entry empty. In one cycle it writes a value there and searches for exactly that value, so the search must miss. A second search then shows the hit. The priority order is reached through three nested prefixes that all accept some keys. Keys are chosen to peel off one level at a time, so each level of the order is exercised.

// File: rtl/tcam_table.sv
module tcam_table #(
  parameter int KEY_W = 32,
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [KEY_W-1:0]            wr_value,
  input  logic [KEY_W-1:0]            wr_care,
  input  logic                        wr_valid,
  output logic [DEPTH-1:0][KEY_W-1:0] value_arr,
  output logic [DEPTH-1:0][KEY_W-1:0] care_arr,
  output logic [DEPTH-1:0]            valid_vec
);

  // decoded write select, one wire per entry
  logic [DEPTH-1:0] row_sel;

  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    assign row_sel[e] = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        value_arr[e] <= '0;
        care_arr[e]  <= '0;
        valid_vec[e] <= 1'b0;
      end else if (row_sel[e]) begin
        value_arr[e] <= wr_value;
        care_arr[e]  <= wr_care;
        valid_vec[e] <= wr_valid;
      end
    end
  end

  // R6: a write lands in the addressed row
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_vec[$past(wr_idx)] == $past(wr_valid)) &&
              (care_arr[$past(wr_idx)] == $past(wr_care)));

  // R6: at most one row is selected per write
  a_r6_single_row: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

endmodule

// File: rtl/tcam_compare.sv
module tcam_compare #(
  parameter int KEY_W = 32,
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0][KEY_W-1:0] value_arr,
  input  logic [DEPTH-1:0][KEY_W-1:0] care_arr,
  input  logic [DEPTH-1:0]            valid_vec,
  input  logic [KEY_W-1:0]            key,
  output logic [DEPTH-1:0]            match_vec
);

  // an entry accepts the key unless a cared-for bit differs
  function automatic logic row_accepts(input logic [KEY_W-1:0] val,
                                       input logic [KEY_W-1:0] care,
                                       input logic             vld,
                                       input logic [KEY_W-1:0] k);
    logic [KEY_W-1:0] diff;
    diff = (val ^ k) & care;
    return vld && (diff == '0);
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign match_vec[e] = row_accepts(value_arr[e], care_arr[e], valid_vec[e], key);
  end

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH-1:0] match_vec,
  output logic             win_hit,
  output logic [IDX_W-1:0] win_idx
);

  // scan from the top so the lowest set bit is the last one written
  always_comb begin
    win_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign win_hit = |match_vec;

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter  int KEY_W = 32,
  parameter  int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_care,
  input  logic             wr_valid,
  input  logic             srch_en,
  input  logic [KEY_W-1:0] srch_key,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx
);

  logic [DEPTH-1:0][KEY_W-1:0] value_arr;
  logic [DEPTH-1:0][KEY_W-1:0] care_arr;
  logic [DEPTH-1:0]            valid_vec;
  logic [DEPTH-1:0]            match_vec;
  logic                        win_hit;
  logic [IDX_W-1:0]            win_idx;

  tcam_table #(.KEY_W(KEY_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_value  (wr_value),
    .wr_care   (wr_care),
    .wr_valid  (wr_valid),
    .value_arr (value_arr),
    .care_arr  (care_arr),
    .valid_vec (valid_vec)
  );

  // compare reads the registered table, so a same-cycle write is not seen
  tcam_compare #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_compare (
    .value_arr (value_arr),
    .care_arr  (care_arr),
    .valid_vec (valid_vec),
    .key       (srch_key),
    .match_vec (match_vec)
  );

  tcam_prio #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_prio (
    .match_vec (match_vec),
    .win_hit   (win_hit),
    .win_idx   (win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= srch_en;
      if (srch_en) begin
        res_hit <= win_hit;
        res_idx <= win_idx;
      end
    end
  end

  // bits strictly below a given index
  function automatic logic [DEPTH-1:0] below_mask(input logic [IDX_W-1:0] idx);
    logic [DEPTH-1:0] m;
    for (int i = 0; i < DEPTH; i++) m[i] = (i < int'(idx));
    return m;
  endfunction

  // R8: one result strobe per search, none otherwise
  a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> res_valid);
  a_r8_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !res_valid);

  // R2: any accepting entry gives a hit
  a_r2_hit_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_en && (match_vec != '0)) |=> res_hit);

  // R5: no accepting entry gives a clean miss
  a_r5_clean_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_en && (match_vec == '0)) |=> (!res_hit && (res_idx == '0)));

  // R4: the winner accepts and nothing below it does
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (match_vec[win_idx] && ((match_vec & below_mask(win_idx)) == '0)));

  // R7: invalid rows never accept
  a_r7_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~valid_vec) == '0);

endmodule

// File: tb/tcam_lookup_test.sv
module tcam_lookup_test;

  localparam int KW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [KW-1:0] wr_value;
  logic [KW-1:0] wr_care;
  logic          wr_valid;
  logic          srch_en;
  logic [KW-1:0] srch_key;
  logic          res_valid;
  logic          res_hit;
  logic [IW-1:0] res_idx;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tcam_lookup uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_value(wr_value), .wr_care(wr_care), .wr_valid(wr_valid),
    .srch_en(srch_en), .srch_key(srch_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // prefix care mask with the top 'len' bits set
  function automatic logic [KW-1:0] prefix(input int len);
    logic [KW-1:0] m;
    for (int i = 0; i < KW; i++) m[i] = (i >= KW - len);
    return m;
  endfunction

  task automatic put(input int idx, input logic [KW-1:0] v,
                     input logic [KW-1:0] c, input logic vld);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_value = v; wr_care = c; wr_valid = vld;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [KW-1:0] k, input bit exp_hit,
                      input int exp_idx, input string tag);
    @(negedge clk);
    srch_en = 1'b1; srch_key = k;
    @(posedge clk); #1;
    chk(res_valid == 1'b1, {tag, " R8 strobe"}, int'(res_valid), 1);
    chk(res_hit == exp_hit, {tag, " hit"}, int'(res_hit), int'(exp_hit));
    chk(int'(res_idx) == exp_idx, {tag, " idx"}, int'(res_idx), exp_idx);
    @(negedge clk);
    srch_en = 1'b0;
    @(posedge clk); #1;
    chk(res_valid == 1'b0, {tag, " R8 quiet"}, int'(res_valid), 0);
  endtask

  task automatic t_reset;
    chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    chk(res_hit == 1'b0, "R1 res_hit", int'(res_hit), 0);
    chk(res_idx == '0, "R1 res_idx", int'(res_idx), 0);
    look(32'h0000_0000, 1'b0, 0, "R1 empty table");
  endtask

  task automatic t_exact;
    put(3, 32'hDEAD_BEEF, '1, 1'b1);
    look(32'hDEAD_BEEF, 1'b1, 3, "R2 exact");
    look(32'hDEAD_BEEE, 1'b0, 0, "R2 one bit off");
  endtask

  task automatic t_wild;
    put(7, 32'h1234_0000, 32'hFFFF_0000, 1'b1);
    look(32'h1234_ABCD, 1'b1, 7, "R3 wildcard low half");
    look(32'h1235_ABCD, 1'b0, 0, "R3 cared bit differs R5");
  endtask

  task automatic t_prefix;
    put(1, 32'h0A01_0100, prefix(24), 1'b1);
    put(2, 32'h0A01_0000, prefix(16), 1'b1);
    put(4, 32'h0A00_0000, prefix(8), 1'b1);
    look(32'h0A01_01FF, 1'b1, 1, "R4 /24 wins");
    look(32'h0A01_02FF, 1'b1, 2, "R4 /16 wins");
    look(32'h0A02_02FF, 1'b1, 4, "R4 /8 wins");
  endtask

  task automatic t_rewrite;
    put(2, 32'hC0A8_0000, prefix(16), 1'b1);
    look(32'h0A01_02FF, 1'b1, 4, "R6 old row 2 gone");
    look(32'hC0A8_1234, 1'b1, 2, "R6 new row 2");
    look(32'h0A01_01FF, 1'b1, 1, "R6 row 1 kept");
    look(32'hDEAD_BEEF, 1'b1, 3, "R6 row 3 kept");
  endtask

  task automatic t_invalid;
    put(1, 32'h0A01_0100, prefix(24), 1'b0);
    look(32'h0A01_01FF, 1'b1, 4, "R7 row 1 removed");
    put(9, 32'h0000_0000, '0, 1'b0);
    look(32'h5555_5555, 1'b0, 0, "R7 invalid wildcard row");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(6); wr_value = 32'hCAFE_F00D; wr_care = '1; wr_valid = 1'b1;
    srch_en = 1'b1; srch_key = 32'hCAFE_F00D;
    @(posedge clk); #1;
    chk(res_valid == 1'b1, "R9 strobe", int'(res_valid), 1);
    chk(res_hit == 1'b0, "R9 old table seen", int'(res_hit), 0);
    @(negedge clk);
    wr_en = 1'b0; srch_en = 1'b0;
    look(32'hCAFE_F00D, 1'b1, 6, "R9 write visible after");
  endtask

  task automatic t_top_row;
    put(15, 32'hFFFF_FFFF, '0, 1'b1);
    look(32'h7777_0000, 1'b1, 15, "R10 default route");
    look(32'hCAFE_F00D, 1'b1, 6, "R10 lower row still wins R4");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_value = '0; wr_care = '0;
    wr_valid = 1'b0; srch_en = 1'b0; srch_key = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_exact;
    t_wild;
    t_prefix;
    t_rewrite;
    t_invalid;
    t_same_cycle;
    t_top_row;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule